// File: doc/BRIEF.md
# Four-Segment Morphing Waveform Generator

This block produces the sample stream of one synthesizer voice. A phase accumulator advances by a programmable step on every sample tick, and each period of the accumulator is cut into four consecutive parts: an upward ramp, a hold at full scale, a downward ramp and a hold at zero. Programming the lengths of the first three parts selects the shape. The zero hold takes whatever remains of the period. A saw, a triangle, a square, narrow pulses and a rough sine all come out of the same datapath. A morph flag turns the full-scale hold into a slice of a period-long falling ramp, so widening a pulse moves the shape smoothly toward a saw.

Software writes the step, the three lengths and the morph flag into a staging set through a small address-decoded write port. The staged values reach the active set only at a period boundary, so no period is built from a mix of old and new settings. The ramp slopes are derived once, when the staged set is taken over, and no division happens per sample. The output is an unsigned sample that is held between ticks and is meant to feed a pulse-width DAC, which typically ticks the block once every 1024 system clocks.

Top module: `wg_morph_gen`

## Requirements
- R1: After reset `sample_out` is 0, the phase is 0, and both the staged and the active settings are step 0, up-ramp 0, hold-high 128, down-ramp 0, morph 0.
- R2: On each cycle with `sample_tick` high, the phase becomes (phase + active step) mod 65536. In that same cycle `sample_out` registers the value for the phase as it was before the add.
- R3: The top 8 phase bits `p` select the part of the period, with cumulative bounds b1 = min(up,256), b2 = min(b1+high,256) and b3 = min(b2+down,256). The up-ramp covers p < b1, the high hold covers b1 <= p < b2, the down-ramp covers b2 <= p < b3, and the zero hold covers the rest.
- R4: In the up-ramp the value is floor(off * floor(65280/up) / 65536), where off = phase - 256*start of the part. In the down-ramp the value is 255 minus the same expression, computed with the down length.
- R5: With morph 0 the high hold gives 255. The zero hold always gives 0.
- R6: With morph 1 the high hold gives 255 - floor(phase*255/65536), which is the falling saw of the whole period.
- R7: A part of length 0 never produces a sample. For example, up=0, high=0, down=256 gives a pure falling saw that starts at 255 on phase 0.
- R8: A write with `wr_en` high stores into the staging set by `wr_addr`: 0 step (16 bits), 1 up length, 2 high length, 3 down length (bits 8:0 of `wr_data` each), 4 morph (bit 0). Addresses 5 to 7 change nothing.
- R9: The staging set is copied into the active set only on a tick whose add carries out of bit 15, or on any tick while the active step is 0. The copy takes effect from the next tick.
- R10: `sample_out` does not change on cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Advance one sample |
| wr_en | input | 1 | Staging register write strobe |
| wr_addr | input | 3 | Staging register select |
| wr_data | input | 16 | Staging register write value |
| sample_out | output | 8 | Unsigned output sample |

## Verification
The scoreboard focuses on the moments where staged settings meet the running waveform. A new shape written in the middle of a period must stay invisible until the carry. A design that copies the staged set early would show a changed sample before the wrap. One that copies late would still use the old shape for a whole extra period. Shapes with zero-length parts, such as a pure saw or a triangle with no hold, catch a design that emits a stray full-scale or zero sample at an empty bound. Lengths whose sum passes 256 catch a design that lets a bound wrap instead of saturating. A step that does not divide the period catches ramp offsets that are taken from the wrong part start. The morph shape and writes to the spare addresses are also compared sample by sample.

// File: rtl/wg_pkg.sv
package wg_pkg;

   typedef enum logic [1:0] {
      SEG_RISE = 2'd0,
      SEG_HIGH = 2'd1,
      SEG_FALL = 2'd2,
      SEG_LOW  = 2'd3
   } wg_seg_e;

   localparam logic [2:0] WA_STEP  = 3'd0;
   localparam logic [2:0] WA_UP    = 3'd1;
   localparam logic [2:0] WA_HOLD  = 3'd2;
   localparam logic [2:0] WA_DOWN  = 3'd3;
   localparam logic [2:0] WA_MORPH = 3'd4;

endpackage

// File: rtl/wg_phase.sv
module wg_phase #(
   parameter int PHASE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [PHASE_W-1:0] step,
   output logic [PHASE_W-1:0] phase,
   output logic               wrap
);

   logic [PHASE_W:0] sum;

   assign sum  = {1'b0, phase} + {1'b0, step};
   assign wrap = tick & sum[PHASE_W];

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase <= '0;
      else if (tick)
         phase <= sum[PHASE_W-1:0];
   end

   assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase));

endmodule

// File: rtl/wg_regs.sv
module wg_regs
   import wg_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int SEG_W   = 8,
   parameter int AMP_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [2:0]                   wr_addr,
   input  logic [PHASE_W-1:0]           wr_data,
   input  logic                         apply,
   output logic [PHASE_W-1:0]           act_step,
   output logic [SEG_W:0]               act_b1,
   output logic [SEG_W:0]               act_b2,
   output logic [SEG_W:0]               act_b3,
   output logic [AMP_W+SEG_W-1:0]       act_slope_up,
   output logic [AMP_W+SEG_W-1:0]       act_slope_dn,
   output logic                         act_morph
);

   localparam int LEN_W   = SEG_W + 1;
   localparam int SLOPE_W = AMP_W + SEG_W;
   localparam logic [LEN_W-1:0]   FULL     = LEN_W'(1) << SEG_W;
   localparam logic [LEN_W-1:0]   HALF     = LEN_W'(1) << (SEG_W - 1);
   localparam logic [AMP_W-1:0]   AMP_MAX  = '1;
   localparam logic [SLOPE_W-1:0] NUMER    = SLOPE_W'(AMP_MAX) << SEG_W;

   initial begin
      assert (PHASE_W >= LEN_W) else $fatal(1, "write data too narrow for lengths");
   end

   // staged settings
   logic [PHASE_W-1:0] sh_step;
   logic [LEN_W-1:0]   sh_len [3];
   logic               sh_morph;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_step   <= '0;
         sh_len[0] <= '0;
         sh_len[1] <= HALF;
         sh_len[2] <= '0;
         sh_morph  <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            WA_STEP:  sh_step   <= wr_data;
            WA_UP:    sh_len[0] <= wr_data[LEN_W-1:0];
            WA_HOLD:  sh_len[1] <= wr_data[LEN_W-1:0];
            WA_DOWN:  sh_len[2] <= wr_data[LEN_W-1:0];
            WA_MORPH: sh_morph  <= wr_data[0];
            default:  ;
         endcase
      end
   end

   // cumulative bounds with saturation at one full period
   function automatic logic [LEN_W-1:0] sat_full(input logic [LEN_W:0] v);
      return (v > {1'b0, FULL}) ? FULL : v[LEN_W-1:0];
   endfunction

   logic [LEN_W-1:0] nb [3];

   always_comb begin
      nb[0] = sat_full({1'b0, sh_len[0]});
      nb[1] = sat_full({1'b0, nb[0]} + {1'b0, sh_len[1]});
      nb[2] = sat_full({1'b0, nb[1]} + {1'b0, sh_len[2]});
   end

   // slopes for the two ramp parts, derived once per take-over
   logic [SLOPE_W-1:0] nslope [2];

   for (genvar gi = 0; gi < 2; gi++) begin : g_slope
      localparam int LIDX = (gi == 0) ? 0 : 2;
      always_comb begin
         if (sh_len[LIDX] == '0)
            nslope[gi] = '0;
         else
            nslope[gi] = NUMER / SLOPE_W'(sh_len[LIDX]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_step     <= '0;
         act_b1       <= '0;
         act_b2       <= HALF;
         act_b3       <= HALF;
         act_slope_up <= '0;
         act_slope_dn <= '0;
         act_morph    <= 1'b0;
      end else if (apply) begin
         act_step     <= sh_step;
         act_b1       <= nb[0];
         act_b2       <= nb[1];
         act_b3       <= nb[2];
         act_slope_up <= nslope[0];
         act_slope_dn <= nslope[1];
         act_morph    <= sh_morph;
      end
   end

   assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable({act_step, act_b1, act_b2, act_b3,
                          act_slope_up, act_slope_dn, act_morph}));

   assert_bounds_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_b1 <= act_b2) && (act_b2 <= act_b3) && (act_b3 <= FULL));

endmodule

// File: rtl/wg_shaper.sv
module wg_shaper
   import wg_pkg::*;
#(
   parameter int PHASE_W  = 16,
   parameter int SEG_W    = 8,
   parameter int AMP_W    = 8,
   parameter bit MORPH_EN = 1'b1
) (
   input  logic [PHASE_W-1:0]     phase,
   input  logic [SEG_W:0]         b1,
   input  logic [SEG_W:0]         b2,
   input  logic [SEG_W:0]         b3,
   input  logic [AMP_W+SEG_W-1:0] slope_up,
   input  logic [AMP_W+SEG_W-1:0] slope_dn,
   input  logic                   morph,
   output wg_seg_e                seg,
   output logic [AMP_W-1:0]       level
);

   localparam int LEN_W   = SEG_W + 1;
   localparam int SLOPE_W = AMP_W + SEG_W;
   localparam int PROD_W  = PHASE_W + SLOPE_W;
   localparam int SAW_W   = PHASE_W + AMP_W;
   localparam logic [AMP_W-1:0] AMP_MAX = '1;

   logic [LEN_W-1:0]   p_top;
   logic [LEN_W-1:0]   start;
   logic [PHASE_W:0]   start_ext;
   logic [PHASE_W-1:0] off;
   logic [SLOPE_W-1:0] slope;
   logic [PROD_W-1:0]  prod;
   logic [SLOPE_W-1:0] ramp_full;
   logic [AMP_W-1:0]   ramp;
   logic [AMP_W-1:0]   hold_hi;

   assign p_top = {1'b0, phase[PHASE_W-1 -: SEG_W]};

   always_comb begin
      if (p_top < b1)      seg = SEG_RISE;
      else if (p_top < b2) seg = SEG_HIGH;
      else if (p_top < b3) seg = SEG_FALL;
      else                 seg = SEG_LOW;
   end

   always_comb begin
      unique case (seg)
         SEG_HIGH: start = b1;
         SEG_FALL: start = b2;
         SEG_LOW:  start = b3;
         default:  start = '0;
      endcase
   end

   assign start_ext = {start, {(PHASE_W - SEG_W){1'b0}}};
   assign off       = PHASE_W'({1'b0, phase} - start_ext);
   assign slope     = (seg == SEG_FALL) ? slope_dn : slope_up;
   assign prod      = PROD_W'(off) * PROD_W'(slope);
   assign ramp_full = SLOPE_W'(prod >> PHASE_W);
   assign ramp      = (ramp_full > SLOPE_W'(AMP_MAX)) ? AMP_MAX : ramp_full[AMP_W-1:0];

   if (MORPH_EN) begin : g_morph
      logic [SAW_W-1:0] saw_prod;
      assign saw_prod = SAW_W'(phase) * SAW_W'(AMP_MAX);
      assign hold_hi  = morph ? (AMP_MAX - AMP_W'(saw_prod >> PHASE_W)) : AMP_MAX;
   end else begin : g_plain
      logic unused_morph;
      assign unused_morph = morph;
      assign hold_hi      = AMP_MAX;
   end

   always_comb begin
      unique case (seg)
         SEG_RISE: level = ramp;
         SEG_HIGH: level = hold_hi;
         SEG_FALL: level = AMP_MAX - ramp;
         default:  level = '0;
      endcase
   end

endmodule

// File: rtl/wg_morph_gen.sv
module wg_morph_gen
   import wg_pkg::*;
#(
   parameter int PHASE_W  = 16,
   parameter int SEG_W    = 8,
   parameter int AMP_W    = 8,
   parameter bit MORPH_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_tick,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [PHASE_W-1:0] wr_data,
   output logic [AMP_W-1:0]   sample_out
);

   localparam int LEN_W   = SEG_W + 1;
   localparam int SLOPE_W = AMP_W + SEG_W;
   localparam logic [AMP_W-1:0] AMP_MAX = '1;

   initial begin
      assert (SEG_W >= 2 && SEG_W < PHASE_W) else $fatal(1, "SEG_W out of range");
      assert (AMP_W >= 1) else $fatal(1, "AMP_W out of range");
   end

   logic [PHASE_W-1:0] phase;
   logic               wrap;
   logic               apply;
   logic [PHASE_W-1:0] act_step;
   logic [LEN_W-1:0]   act_b1, act_b2, act_b3;
   logic [SLOPE_W-1:0] act_slope_up, act_slope_dn;
   logic               act_morph;
   wg_seg_e            seg;
   logic [AMP_W-1:0]   level;

   assign apply = sample_tick & (wrap | (act_step == '0));

   wg_phase #(.PHASE_W(PHASE_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sample_tick),
      .step  (act_step),
      .phase (phase),
      .wrap  (wrap)
   );

   wg_regs #(.PHASE_W(PHASE_W), .SEG_W(SEG_W), .AMP_W(AMP_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .apply        (apply),
      .act_step     (act_step),
      .act_b1       (act_b1),
      .act_b2       (act_b2),
      .act_b3       (act_b3),
      .act_slope_up (act_slope_up),
      .act_slope_dn (act_slope_dn),
      .act_morph    (act_morph)
   );

   wg_shaper #(.PHASE_W(PHASE_W), .SEG_W(SEG_W), .AMP_W(AMP_W), .MORPH_EN(MORPH_EN)) u_shaper (
      .phase    (phase),
      .b1       (act_b1),
      .b2       (act_b2),
      .b3       (act_b3),
      .slope_up (act_slope_up),
      .slope_dn (act_slope_dn),
      .morph    (act_morph),
      .seg      (seg),
      .level    (level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         sample_out <= '0;
      else if (sample_tick)
         sample_out <= level;
   end

   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(sample_out));

   assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && seg == SEG_LOW) |=> (sample_out == '0));

   assert_high_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && seg == SEG_HIGH && !act_morph) |=> (sample_out == AMP_MAX));

endmodule

// File: tb/wg_morph_gen_test.sv
`timescale 1ns/1ps
module wg_morph_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  sample_out;

   always #2.5 clk = ~clk;

   wg_morph_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .sample_out  (sample_out)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model state
   int m_phase;
   int s_step, s_up, s_hi, s_dn, s_m;
   int a_step, a_up, a_hi, a_dn, a_m;

   int    exp_q [$];
   string tag_q [$];
   logic  pend = 1'b0;
   int    last_seen = 0;

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int ref_wave(int ph, int up, int hi, int dn, int m);
      int p, b1, b2, b3;
      longint off;
      p  = ph >> 8;
      b1 = imin(up, 256);
      b2 = imin(b1 + hi, 256);
      b3 = imin(b2 + dn, 256);
      if (p < b1) begin
         off = ph;
         return int'((off * (65280 / up)) >> 16);
      end else if (p < b2) begin
         if (m != 0) return 255 - int'((longint'(ph) * 255) >> 16);
         return 255;
      end else if (p < b3) begin
         off = ph - b2 * 256;
         return 255 - int'((off * (65280 / dn)) >> 16);
      end
      return 0;
   endfunction

   task automatic write_reg(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(addr);
      wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
      case (addr)
         0: s_step = data & 16'hFFFF;
         1: s_up   = data & 9'h1FF;
         2: s_hi   = data & 9'h1FF;
         3: s_dn   = data & 9'h1FF;
         4: s_m    = data & 1;
         default: ;
      endcase
   endtask

   task automatic drive_tick(input string tag);
      int sum;
      bit app;
      exp_q.push_back(ref_wave(m_phase, a_up, a_hi, a_dn, a_m));
      tag_q.push_back(tag);
      sum = m_phase + a_step;
      app = (sum > 65535) || (a_step == 0);
      m_phase = sum & 16'hFFFF;
      if (app) begin
         a_step = s_step; a_up = s_up; a_hi = s_hi; a_dn = s_dn; a_m = s_m;
      end
      @(negedge clk);
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) drive_tick(tag);
   endtask

   // monitor side of the scoreboard
   always @(posedge clk) pend <= sample_tick;

   always @(negedge clk) begin
      if (pend) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: unexpected sample %0d, expected nothing", sample_out);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (int'(sample_out) != e) begin
               n_bad++;
               $display("FAIL %s: sample actual %0d expected %0d", t, sample_out, e);
            end
            last_seen = int'(sample_out);
         end
      end
   end

   task automatic check_hold(input string tag);
      for (int i = 0; i < 6; i++) @(negedge clk);
      n_cmp++;
      if (int'(sample_out) != last_seen) begin
         n_bad++;
         $display("FAIL %s: held sample actual %0d expected %0d", tag, sample_out, last_seen);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      finish_run();
   end

   initial begin
      m_phase = 0;
      s_step = 0; s_up = 0; s_hi = 128; s_dn = 0; s_m = 0;
      a_step = 0; a_up = 0; a_hi = 128; a_dn = 0; a_m = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      n_cmp++;
      if (sample_out !== 8'd0) begin
         n_bad++;
         $display("FAIL R1: reset sample actual %0d expected 0", sample_out);
      end
      drive_tick("R1");

      // R2 R4 trapezoid, 64 ticks per period, taken over at once (step 0)
      write_reg(0, 16'h0400);
      write_reg(1, 64);
      write_reg(2, 64);
      write_reg(3, 64);
      run_ticks(70, "R4");
      check_hold("R10");

      // R9 saw staged mid-period; R7 empty up and high parts
      write_reg(1, 0);
      write_reg(2, 0);
      write_reg(3, 256);
      run_ticks(75, "R9");

      // R3 triangle with a step that does not divide the period
      write_reg(0, 16'h0333);
      write_reg(1, 128);
      write_reg(2, 0);
      write_reg(3, 128);
      run_ticks(90, "R3");

      // R6 morph: wide pulse into saw
      write_reg(0, 16'h0500);
      write_reg(1, 0);
      write_reg(2, 200);
      write_reg(3, 0);
      write_reg(4, 1);
      run_ticks(60, "R6");

      // R5 square, morph off
      write_reg(4, 0);
      write_reg(2, 128);
      run_ticks(60, "R5");

      // R7 rough sine with all four parts
      write_reg(1, 85);
      write_reg(2, 43);
      write_reg(3, 85);
      run_ticks(60, "R7");

      // R3 lengths that add past a full period saturate
      write_reg(1, 200);
      write_reg(2, 100);
      write_reg(3, 50);
      run_ticks(60, "R3");

      // R8 spare addresses change nothing
      write_reg(5, 16'hFFFF);
      write_reg(6, 16'h0001);
      write_reg(7, 16'h1234);
      run_ticks(60, "R8");
      check_hold("R10");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R2: pending samples actual %0d expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule